// File: doc/BRIEF.md
# Disk Track Sector Header Checker

This block watches the deserialized byte stream coming off one disk track and checks every record on it. A record starts with a sync byte, carries an eight-byte header (cylinder, head, record number, data length and a header check word), and, when the header announces a non-zero length, a data field of exactly that many bytes followed by its own check word. Sectors are therefore of variable length, and the checker counts its way through each one from the length it has just read. The first record on a track is the home address, which is a header with zero length.

Each header's cylinder and head are compared against an expected position that is captured when the index pulse arrives. Stepping across positions is done by changing the expected inputs before each index. Repeating the check on one position is done by leaving them unchanged. After each record the read gate is dropped for a programmable number of byte times, which covers the place where a writer may have spliced the track. It is then raised again so the checker can hunt for the next sync byte. Every record yields a one-cycle result pulse. The index pulse latches per-track totals of good records, check-word failures and position mismatches.

Top module: `sector_hdr_checker`

## Requirements
- R1: While reset is asserted and directly after it, read_gate is 1, rec_done, rec_crc_bad, rec_addr_bad and track_done are 0, and all three count outputs are 0.
- R2: While hunting, only the sync byte 0xA1 starts a record and every other byte is ignored. The eight header bytes that follow are, in order: cylinder high, cylinder low, head, record number, length high, length low, check high, check low.
- R3: Check words are CRC-16 with polynomial 0x1021, preset 0xFFFF, most significant bit first and no final inversion. The header check covers the six header bytes after the sync byte. The data check covers the data bytes only. Each check word is sent high byte first. A failing check word ends the record with rec_crc_bad set.
- R4: A header with non-zero length is followed by exactly that many data bytes and then two check bytes, and a sync value inside the data does not restart parsing. A zero length (home-address form) ends the record after the header.
- R5: When every check word of a record passes but its cylinder or head differs from the expected position, the record ends with rec_addr_bad set. A check-word failure takes precedence and sets only rec_crc_bad.
- R6: The expected cylinder and head are captured at each index pulse. Changes on those inputs in the middle of a track have no effect until the next index.
- R7: When the header check fails, the length is not trusted and the record ends after the header check bytes.
- R8: After a record ends, read_gate is 0 for exactly gap_bytes byte strobes, and bytes in that window (sync values included) are ignored. With gap_bytes of 0 the checker hunts again at once.
- R9: rec_done is a one-cycle pulse in the cycle after the record's last byte is taken. At most one of rec_crc_bad and rec_addr_bad accompanies it, and neither is ever high without it.
- R10: An index pulse latches the running totals onto the count outputs, clears the running totals, abandons any partial record, returns to hunting with read_gate high, and pulses track_done in the next cycle. The count outputs change only at that moment.
- R11: Each running total saturates at 2^CNT_W - 1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Strobe marking a valid byte on byte_in |
| byte_in | input | 8 | Deserialized track byte |
| index_pls | input | 1 | Track index pulse: end of scan, latch totals |
| exp_cyl | input | 16 | Expected cylinder, captured at index |
| exp_head | input | 8 | Expected head, captured at index |
| gap_bytes | input | GAP_W | Byte times the read gate stays low after a record |
| read_gate | output | 1 | High while hunting or reading a record |
| rec_done | output | 1 | One-cycle pulse when a record ends |
| rec_crc_bad | output | 1 | Record ended on a failing check word |
| rec_addr_bad | output | 1 | Record was intact but at the wrong position |
| track_done | output | 1 | One-cycle pulse after an index latch |
| good_count | output | CNT_W | Good records of the last track |
| crc_count | output | CNT_W | Check-word failures of the last track |
| addr_count | output | CNT_W | Position mismatches of the last track |

## Verification
The hardest situation to reach is a header whose check word fails while its length field is non-zero. The checker then has to give up the data field and let the gap hide whatever follows. The bench creates it by flipping one bit of the header check word and sending only gap filler, made of sync values, before the next record. A correct design therefore ignores those fillers and parses the next record cleanly. The bench also sweeps record lengths, gap lengths and expected positions across several tracks. It cuts a header off with an index pulse, and it pushes a total past its saturation point.

// File: rtl/shc_pkg.sv
package shc_pkg;

  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_HDR  = 3'd1,
    ST_DATA = 3'd2,
    ST_DCRC = 3'd3,
    ST_GAP  = 3'd4
  } shc_state_e;

  localparam int CYL_W   = 16;
  localparam int HEAD_W  = 8;
  localparam int LEN_W   = 16;
  localparam int HDR_LEN = 8;   // bytes after the sync byte

  // One byte through the CCITT polynomial, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  data);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

endpackage

// File: rtl/shc_crc16.sv
module shc_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_nx
);
  import shc_pkg::*;

  logic [15:0] crc_q;

  always_comb crc_nx = crc16_step(crc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 16'hFFFF;
    else if (init) crc_q <= 16'hFFFF;
    else if (en)   crc_q <= crc_nx;
  end
endmodule

// File: rtl/shc_tally.sv
module shc_tally #(
  parameter int CNT_W = 8,
  parameter int NUM   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      latch,
  input  logic [NUM-1:0]            ev,
  output logic [NUM-1:0][CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= '0;
      else if (latch)                  run_q <= '0;
      else if (ev[g] && run_q != MAXV) run_q <= run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= '0;
      else if (latch) out_q <= run_q;
    end

    assign total[g] = out_q;
  end
endmodule

// File: rtl/sector_hdr_checker.sv
module sector_hdr_checker #(
  parameter logic [7:0] SYNC_BYTE = 8'hA1,
  parameter int         GAP_W     = 8,
  parameter int         CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             index_pls,
  input  logic [15:0]      exp_cyl,
  input  logic [7:0]       exp_head,
  input  logic [GAP_W-1:0] gap_bytes,
  output logic             read_gate,
  output logic             rec_done,
  output logic             rec_crc_bad,
  output logic             rec_addr_bad,
  output logic             track_done,
  output logic [CNT_W-1:0] good_count,
  output logic [CNT_W-1:0] crc_count,
  output logic [CNT_W-1:0] addr_count
);
  import shc_pkg::*;

  localparam int               CNTR_W   = LEN_W;
  localparam logic [CNTR_W-1:0] HDR_LAST = CNTR_W'(HDR_LEN - 1);

  shc_state_e        state_q, state_d;
  logic [CNTR_W-1:0] cnt_q, cnt_d;
  logic [CYL_W-1:0]  cyl_q, cyl_d, exp_cyl_q;
  logic [HEAD_W-1:0] head_q, head_d, exp_head_q;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              pend_q, pend_d;
  logic              crc_init, crc_en;
  logic [15:0]       crc_nx;
  logic              rec_end, end_crc_bad, end_addr_bad;
  logic              pos_miss, gap_done;
  logic              rec_done_q, crc_bad_q, addr_bad_q, trk_q;
  logic [2:0]              ev;
  logic [2:0][CNT_W-1:0]   totals;

  shc_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (crc_init),
    .en     (crc_en),
    .din    (byte_in),
    .crc_nx (crc_nx)
  );

  assign pos_miss = (cyl_q != exp_cyl_q) || (head_q != exp_head_q);
  assign gap_done = (cnt_q + 1'b1) >= CNTR_W'(gap_bytes);

  // Next-state logic
  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    cyl_d        = cyl_q;
    head_d       = head_q;
    len_d        = len_q;
    pend_d       = pend_q;
    crc_init     = 1'b0;
    crc_en       = 1'b0;
    rec_end      = 1'b0;
    end_crc_bad  = 1'b0;
    end_addr_bad = 1'b0;
    if (index_pls) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else if (byte_vld) begin
      case (state_q)
        ST_HUNT: begin
          if (byte_in == SYNC_BYTE) begin
            state_d  = ST_HDR;
            cnt_d    = '0;
            crc_init = 1'b1;
          end
        end
        ST_HDR: begin
          crc_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          case (cnt_q[2:0])
            3'd0:    cyl_d[15:8] = byte_in;
            3'd1:    cyl_d[7:0]  = byte_in;
            3'd2:    head_d      = byte_in;
            3'd4:    len_d[15:8] = byte_in;
            3'd5:    len_d[7:0]  = byte_in;
            default: ;
          endcase
          if (cnt_q == HDR_LAST) begin
            if (crc_nx != 16'h0000) begin
              rec_end     = 1'b1;
              end_crc_bad = 1'b1;
            end else if (len_q == '0) begin
              rec_end      = 1'b1;
              end_addr_bad = pos_miss;
            end else begin
              state_d  = ST_DATA;
              cnt_d    = '0;
              crc_init = 1'b1;
              pend_d   = pos_miss;
            end
          end
        end
        ST_DATA: begin
          crc_en = 1'b1;
          if (cnt_q == len_q - 1'b1) begin
            state_d = ST_DCRC;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DCRC: begin
          crc_en = 1'b1;
          if (cnt_q[0]) begin
            rec_end = 1'b1;
            if (crc_nx != 16'h0000) end_crc_bad  = 1'b1;
            else                    end_addr_bad = pend_q;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            state_d = ST_HUNT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
      if (rec_end) begin
        state_d = (gap_bytes == '0) ? ST_HUNT : ST_GAP;
        cnt_d   = '0;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      cyl_q   <= '0;
      head_q  <= '0;
      len_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cyl_q   <= cyl_d;
      head_q  <= head_d;
      len_q   <= len_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cyl_q  <= '0;
      exp_head_q <= '0;
    end else if (index_pls) begin
      exp_cyl_q  <= exp_cyl;
      exp_head_q <= exp_head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_done_q <= 1'b0;
      crc_bad_q  <= 1'b0;
      addr_bad_q <= 1'b0;
      trk_q      <= 1'b0;
    end else begin
      rec_done_q <= rec_end;
      crc_bad_q  <= end_crc_bad;
      addr_bad_q <= end_addr_bad;
      trk_q      <= index_pls;
    end
  end

  assign ev = {end_addr_bad, end_crc_bad, rec_end && !end_crc_bad && !end_addr_bad};

  shc_tally #(.CNT_W(CNT_W), .NUM(3)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .latch (index_pls),
    .ev    (ev),
    .total (totals)
  );

  assign read_gate    = (state_q != ST_GAP);
  assign rec_done     = rec_done_q;
  assign rec_crc_bad  = crc_bad_q;
  assign rec_addr_bad = addr_bad_q;
  assign track_done   = trk_q;
  assign good_count   = totals[0];
  assign crc_count    = totals[1];
  assign addr_count   = totals[2];
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
  parameter int GAP_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             index_pls,
  input logic [GAP_W-1:0] gap_bytes,
  input logic             read_gate,
  input logic             rec_done,
  input logic             rec_crc_bad,
  input logic             rec_addr_bad,
  input logic             track_done,
  input logic [CNT_W-1:0] good_count,
  input logic [CNT_W-1:0] crc_count,
  input logic [CNT_W-1:0] addr_count
);

  assert_gap_closes_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && ($past(gap_bytes) != '0)) |-> !read_gate);

  assert_gate_falls_on_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_gate) |-> rec_done);

  assert_flags_need_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_crc_bad || rec_addr_bad) |-> rec_done);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_crc_bad, rec_addr_bad}));

  assert_index_reopens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    index_pls |=> (read_gate && track_done && !rec_done));

  assert_counts_only_at_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(good_count) || !$stable(crc_count) || !$stable(addr_count)) |-> track_done);

endmodule

bind sector_hdr_checker shc_checker #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_shc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .index_pls    (index_pls),
  .gap_bytes    (gap_bytes),
  .read_gate    (read_gate),
  .rec_done     (rec_done),
  .rec_crc_bad  (rec_crc_bad),
  .rec_addr_bad (rec_addr_bad),
  .track_done   (track_done),
  .good_count   (good_count),
  .crc_count    (crc_count),
  .addr_count   (addr_count)
);

// File: tb/sector_hdr_checker_tb.sv
module sector_hdr_checker_tb;

  localparam logic [7:0] SYNC = 8'hA1;
  localparam int         SATV = 255;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_in;
  logic        index_pls;
  logic [15:0] exp_cyl;
  logic [7:0]  exp_head;
  logic [7:0]  gap_bytes;
  logic        read_gate, rec_done, rec_crc_bad, rec_addr_bad, track_done;
  logic [7:0]  good_count, crc_count, addr_count;

  int n_checks = 0;
  int n_errors = 0;
  int e_good = 0, e_crc = 0, e_addr = 0;
  logic [15:0] t_cyl = '0;
  logic [7:0]  t_head = '0;

  always #10 clk = ~clk;

  sector_hdr_checker u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .index_pls(index_pls), .exp_cyl(exp_cyl), .exp_head(exp_head),
    .gap_bytes(gap_bytes), .read_gate(read_gate), .rec_done(rec_done),
    .rec_crc_bad(rec_crc_bad), .rec_addr_bad(rec_addr_bad),
    .track_done(track_done), .good_count(good_count),
    .crc_count(crc_count), .addr_count(addr_count)
  );

  function automatic logic [15:0] ccitt(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic tick(inout int c);
    if (c < SATV) c++;
  endtask

  task automatic index_check(input string req);
    @(negedge clk);
    index_pls = 1'b1;
    @(negedge clk);
    index_pls = 1'b0;
    chk({req, " track_done"}, int'(track_done), 1);
    chk({req, " good"}, int'(good_count), e_good);
    chk({req, " crc"},  int'(crc_count),  e_crc);
    chk({req, " addr"}, int'(addr_count), e_addr);
    chk("R10 gate after index", int'(read_gate), 1);
    e_good = 0; e_crc = 0; e_addr = 0;
    t_cyl = exp_cyl; t_head = exp_head;
  endtask

  task automatic send_record(input logic [15:0] cyl, input logic [7:0] head,
                             input logic [7:0] recno, input logic [15:0] len,
                             input bit bad_hdr, input bit bad_data,
                             input logic [7:0] seed);
    logic [7:0]  h [6];
    logic [15:0] c;
    logic [7:0]  d;
    bit          cbad, abad;
    h[0] = cyl[15:8]; h[1] = cyl[7:0]; h[2] = head; h[3] = recno;
    h[4] = len[15:8]; h[5] = len[7:0];
    c = 16'hFFFF;
    put_byte(SYNC);
    for (int i = 0; i < 6; i++) begin
      put_byte(h[i]);
      c = ccitt(c, h[i]);
    end
    if (bad_hdr) c = c ^ 16'h0100;
    put_byte(c[15:8]);
    put_byte(c[7:0]);
    if (!bad_hdr && len != 0) begin
      chk("R4 no result before data", int'(rec_done), 0);
      c = 16'hFFFF;
      for (int i = 0; i < int'(len); i++) begin
        d = (i == 0) ? SYNC : 8'(seed + 8'(i * 29));
        put_byte(d);
        c = ccitt(c, d);
      end
      if (bad_data) c = c ^ 16'h0001;
      put_byte(c[15:8]);
      put_byte(c[7:0]);
    end
    cbad = bad_hdr || (len != 0 && bad_data);
    abad = !cbad && (cyl != t_cyl || head != t_head);
    chk("R9 rec_done pulse", int'(rec_done), 1);
    chk(bad_hdr ? "R7 header check fail" : "R3 check result", int'(rec_crc_bad), int'(cbad));
    chk("R5 position result", int'(rec_addr_bad), int'(abad));
    if (cbad)      tick(e_crc);
    else if (abad) tick(e_addr);
    else           tick(e_good);
  endtask

  task automatic gap_run(input int n);
    for (int k = 0; k < n; k++) begin
      chk("R8 gate low in gap", int'(read_gate), 0);
      put_byte(SYNC);
    end
    chk("R8 gate high after gap", int'(read_gate), 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; byte_in = '0; index_pls = 1'b0;
    exp_cyl = 16'h0123; exp_head = 8'd2; gap_bytes = 8'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset gate", int'(read_gate), 1);
    chk("R1 reset rec_done", int'(rec_done), 0);
    chk("R1 reset track_done", int'(track_done), 0);
    chk("R1 reset counts", int'(good_count) + int'(crc_count) + int'(addr_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gate after release", int'(read_gate), 1);
    index_check("R10 first index");

    // R2: junk while hunting is ignored
    put_byte(8'h00); put_byte(8'h55); put_byte(8'hF0);
    chk("R2 junk ignored", int'(rec_done), 0);
    chk("R2 gate during hunt", int'(read_gate), 1);

    // Track with one of each outcome
    send_record(16'h0123, 8'd2, 8'd0, 16'd0, 0, 0, 8'h10); gap_run(3);   // home address
    send_record(16'h0123, 8'd2, 8'd1, 16'd5, 0, 0, 8'h20); gap_run(3);   // R4
    send_record(16'h0123, 8'd2, 8'd2, 16'd1, 0, 1, 8'h30); gap_run(3);   // R3 data
    send_record(16'h0123, 8'd2, 8'd3, 16'd7, 1, 0, 8'h40); gap_run(3);   // R7
    send_record(16'h0123, 8'd3, 8'd4, 16'd2, 0, 0, 8'h50); gap_run(3);   // R5 head
    send_record(16'h0124, 8'd2, 8'd5, 16'd0, 0, 0, 8'h60); gap_run(3);   // R5 cyl
    send_record(16'h0124, 8'd2, 8'd6, 16'd3, 0, 1, 8'h70); gap_run(3);   // R5 precedence
    exp_cyl = 16'h0999;                                                  // R6
    send_record(16'h0123, 8'd2, 8'd7, 16'd2, 0, 0, 8'h80); gap_run(3);
    send_record(16'h0999, 8'd2, 8'd8, 16'd0, 0, 0, 8'h90); gap_run(3);
    index_check("R10 mixed track");

    // Sweep of positions, gap lengths and record lengths
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < 3; g++) begin
        exp_cyl  = 16'(p * 257 + 5);
        exp_head = 8'(p);
        gap_bytes = 8'(g);
        index_check("R10 sweep");
        for (int l = 0; l < 5; l++) begin
          int v;
          v = (l + p + g) % 4;
          send_record(exp_cyl, (v == 2) ? exp_head + 8'd1 : exp_head, 8'(l),
                      16'(l), (v == 3), (v == 1), 8'(p * 16 + l));
          gap_run(g);
        end
      end
    end
    index_check("R6 R10 sweep end");

    // Partial header abandoned by index
    gap_bytes = 8'd2;
    put_byte(SYNC); put_byte(t_cyl[15:8]); put_byte(t_cyl[7:0]); put_byte(t_head);
    index_check("R10 partial abandon");
    send_record(t_cyl, t_head, 8'd0, 16'd2, 0, 0, 8'h33); gap_run(2);
    index_check("R10 after partial");

    // Saturation
    gap_bytes = 8'd0;
    for (int r = 0; r < 260; r++) begin
      send_record(t_cyl, t_head, 8'(r), 16'd0, 0, 0, 8'h00);
    end
    chk("R11 expected saturated", e_good, SATV);
    index_check("R11 saturation");

    finish_run();
  end

endmodule